// File: doc/BRIEF.md
# Bidirectional Pin Port with Direction-Change Gap

This block is an 8-bit general-purpose pin port that a processor controls through a small register bus. Software sets each pin as an input or an output, sets the level driven on output pins, and reads the level present on every pin. The pin level is read back through a two-stage capture path. The first stage takes the pin level as the clock falls and holds it while the clock is low. The second stage loads that held value into the readable pin register on the next rising edge.

An optional break-before-make mode protects against drive contention when software turns a pin around. With the mode enabled, each pin whose direction bit changes on a direction write stops driving for one whole clock cycle. After that cycle the new direction applies. Pins whose direction bit does not change are not affected.

The register map has four locations. Location 0 is the captured pin levels and is read-only. Location 1 is the direction register, where 1 means output. Location 2 is the output value register. Bit 0 of location 3 enables the break-before-make mode.

Top module: `gpio_bbm_port`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. pin_oe is 0 and pin_out is 0.
- R2: Reading location 1 or 2 returns the value last written there, starting in the cycle after the write edge. Location 3 returns the mode bit in bit 0 and zeros in all other bits.
- R3: Location 0 returns the captured pin levels for both input and output pins. A write to location 0 changes no register and no output.
- R4: pin_out equals the output register from the edge that samples the write. When break-before-make is not forcing a gap, pin_oe bit n equals direction bit n.
- R5: A pin level that changes during the clock-high phase shows at location 0 after the next rising edge. A level that changes during the clock-low phase does not show after the next rising edge. It shows after the rising edge that follows.
- R6: With the mode bit at 0, a direction write takes effect on pin_oe at the edge that samples it, with no gap.
- R7: With the mode bit at 1, every pin whose direction bit is changed by a write has pin_oe at 0 for exactly one cycle after the sampling edge. After that cycle it takes the new direction.
- R8: During that gap cycle, pins whose direction bit was not changed keep their pin_oe value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register location |
| bus_wdata | input | 8 | Write data |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Levels present on the pins |
| pin_oe | output | 8 | Per-pin drive enable |
| pin_out | output | 8 | Per-pin driven level |

## Verification
The assertions take two things for granted. First, the bus is driven with settled values around each rising edge. Second, the read address stays steady for the cycle after a write whose readback is checked. The bench meets both by changing the bus only one nanosecond after a falling edge. The pin levels are changed only at points well inside a clock phase, never on the falling edge where capture happens. This is what makes the expected half-cycle or one-and-a-half-cycle capture delay deterministic. The direction-gap properties compare pin_oe with the direction value held before the write, so they hold for back-to-back direction writes as well.

// File: rtl/gpio_bbm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the pin port: register locations.
package gpio_bbm_pkg;

    // Register locations on the bus; the order fixes the software map.
    typedef enum logic [1:0] {
        REG_PIN = 2'd0,
        REG_DIR = 2'd1,
        REG_OUT = 2'd2,
        REG_CFG = 2'd3
    } gpio_reg_e;

    // Bit of the configuration location that enables the turn-around gap.
    localparam int unsigned CFG_BBM_BIT = 0;

endpackage

// File: rtl/gpio_bbm_regs.sv
`timescale 1ns/1ps
// Register bank of the pin port: direction, output value and mode bit.
// Assumes bus_wr_en and bus_addr are stable around the rising edge.
// Writes to the pin location are dropped here.
module gpio_bbm_regs
    import gpio_bbm_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic             bbm_en_q,
    output logic             dir_wr
);

    logic out_wr;
    logic cfg_wr;

    // Decode which register a write targets.
    always_comb begin
        dir_wr = wr_en && (addr == REG_DIR);
        out_wr = wr_en && (addr == REG_OUT);
        cfg_wr = wr_en && (addr == REG_CFG);
    end

    // Hold direction, output value and mode bit; all clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            out_q    <= '0;
            bbm_en_q <= 1'b0;
        end else begin
            if (dir_wr) dir_q    <= wdata;
            if (out_wr) out_q    <= wdata;
            if (cfg_wr) bbm_en_q <= wdata[CFG_BBM_BIT];
        end
    end

endmodule

// File: rtl/gpio_bbm_dir.sv
`timescale 1ns/1ps
// Drive-enable stage. It applies the direction register to the pins and,
// when the turn-around mode is on, blanks every pin whose direction bit
// flips for the one cycle after the write edge.
// Assumes dir_q is the register value before the edge that samples dir_wr.
module gpio_bbm_dir #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_wr,
    input  logic             bbm_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] oe
);

    logic [WIDTH-1:0] flip;
    logic [WIDTH-1:0] gap_q;

    // Pins whose direction the pending write would change.
    always_comb flip = wdata ^ dir_q;

    // Record the pins to blank for one cycle; clear after that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_q <= '0;
        else if (dir_wr && bbm_en) gap_q <= flip;
        else                       gap_q <= '0;
    end

    // Drive enable per pin, forced off while in the gap.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_oe
            assign oe[i] = dir_q[i] & ~gap_q[i];
        end
    endgenerate

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Two-stage pin capture, one copy per pin.
// Stage one closes on the falling clock edge: it follows the pin while the
// clock is high and holds its value while the clock is low. Stage two loads
// the held value on the next rising edge.
// Assumes pin levels are not changed exactly on a falling edge.
module gpio_in_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic hold_q;

            // Stage one: value frozen at the end of the high phase.
            always_ff @(negedge clk) begin
                hold_q <= pin_in[i];
            end

            // Stage two: readable pin bit, loaded on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) pin_q[i] <= 1'b0;
                else        pin_q[i] <= hold_q;
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_bbm_port.sv
`timescale 1ns/1ps
// Pin port top: register bank, drive-enable stage with the turn-around
// gap, pin capture, and the read multiplexer.
// Assumes WIDTH >= 2 so that location 3 has bits to read as zero.
module gpio_bbm_port
    import gpio_bbm_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_wr_en,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pin_q;
    logic             bbm_en_q;
    logic             dir_wr;

    gpio_bbm_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .bbm_en_q (bbm_en_q),
        .dir_wr   (dir_wr)
    );

    gpio_bbm_dir #(.WIDTH(WIDTH)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_wr (dir_wr),
        .bbm_en (bbm_en_q),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .oe     (pin_oe)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .pin_q  (pin_q)
    );

    // Driven level follows the output register.
    assign pin_out = out_q;

    // Read multiplexer over the four locations.
    always_comb begin
        unique case (gpio_reg_e'(bus_addr))
            REG_PIN: bus_rdata = pin_q;
            REG_DIR: bus_rdata = dir_q;
            REG_OUT: bus_rdata = out_q;
            REG_CFG: bus_rdata = {{(WIDTH-1){1'b0}}, bbm_en_q};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bbm_port_chk.sv
`timescale 1ns/1ps
// Property checker for the pin port. It is bound into every instance of the top.
module gpio_bbm_port_chk
    import gpio_bbm_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic             bus_wr_en,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] dir_q,
    input logic             bbm_en_q
);

    logic wr_dir;
    logic wr_out;
    assign wr_dir = bus_wr_en && (bus_addr == REG_DIR);
    assign wr_out = bus_wr_en && (bus_addr == REG_OUT);

    // R7: pins flipped by a write are undriven in the next cycle.
    p_gap_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir && bbm_en_q) |=> ((pin_oe & $past(bus_wdata ^ dir_q)) == '0));

    // R8: unflipped pins keep their drive enable during the gap.
    p_gap_others_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir && bbm_en_q) |=>
        ((pin_oe & ~$past(bus_wdata ^ dir_q)) == ($past(dir_q) & ~$past(bus_wdata ^ dir_q))));

    // R6: without the mode, the new direction is applied at once.
    p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir && !bbm_en_q) |=> (pin_oe == $past(bus_wdata)));

    // R4: with no direction write in the previous cycle, enable equals direction.
    p_oe_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> (pin_oe == dir_q));

    // R4: the driven level follows the output register write.
    p_out_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> (pin_out == $past(bus_wdata)));

    // R2: the direction location reads back the written value.
    p_dir_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> ((bus_addr != REG_DIR) || (bus_rdata == $past(bus_wdata))));

    // R2: the upper bits of the configuration location read zero.
    p_cfg_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CFG) |-> (bus_rdata[WIDTH-1:1] == '0 && bus_rdata[0] == bbm_en_q));

endmodule

bind gpio_bbm_port gpio_bbm_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr_en (bus_wr_en),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .dir_q     (dir_q),
    .bbm_en_q  (bbm_en_q)
);

// File: tb/gpio_bbm_port_tb.sv
`timescale 1ns/1ps
// Directed bench for the pin port. Each scenario task checks its own results.
module gpio_bbm_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_bbm_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr_en (bus_wr_en),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Write one location; returns just after the sampling edge (low phase).
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk); #1;
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reg read", v, 8'h00);
        end
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_readback();
        logic [7:0] v;
        wr(2'd2, 8'h5A);
        rd(2'd2, v); chk("R2 out readback", v, 8'h5A);
        chk("R4 pin_out level", pin_out, 8'h5A);
        wr(2'd3, 8'hFE);
        rd(2'd3, v); chk("R2 cfg upper bits zero", v, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_no_gap();
        logic [7:0] v;
        wr(2'd1, 8'h0F);
        chk("R6 oe at once", pin_oe, 8'h0F);
        rd(2'd1, v); chk("R2 dir readback", v, 8'h0F);
        @(negedge clk); #1;
        chk("R4 oe equals dir", pin_oe, 8'h0F);
    endtask

    task automatic t_gap();
        logic [7:0] v;
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R2 cfg mode bit", v, 8'h01);
        wr(2'd1, 8'h3C);
        chk("R7 R8 gap cycle", pin_oe, 8'h0C);
        @(negedge clk); #1;
        chk("R7 after gap", pin_oe, 8'h3C);
        // Back-to-back: second write's gap covers only its own flips.
        @(negedge clk); #1;
        bus_addr = 2'd1; bus_wdata = 8'hFF; bus_wr_en = 1'b1;
        @(negedge clk); #1;
        chk("R7 first of pair", pin_oe, 8'h3C);
        bus_wdata = 8'hF0;
        @(negedge clk); #1;
        bus_wr_en = 1'b0;
        chk("R8 second of pair", pin_oe, 8'hF0);
        @(negedge clk); #1;
        chk("R7 pair settled", pin_oe, 8'hF0);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_pin_read();
        logic [7:0] v;
        wr(2'd1, 8'hFF);
        pin_in = 8'hA5;
        repeat (3) @(negedge clk);
        #1;
        rd(2'd0, v); chk("R3 pins read as outputs", v, 8'hA5);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R3 write to pin loc ignored", v, 8'hA5);
        rd(2'd1, v); chk("R3 dir untouched", v, 8'hFF);
        rd(2'd2, v); chk("R3 out untouched", v, 8'h5A);
        chk("R3 pin_out untouched", pin_out, 8'h5A);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_capture_delay();
        logic [7:0] v;
        bus_addr = 2'd0;
        // Change in the high phase: visible after the next rising edge.
        @(posedge clk); #1;
        pin_in = 8'h3C;
        @(posedge clk); #1;
        rd(2'd0, v); chk("R5 high-phase change", v, 8'h3C);
        // Change in the low phase: needs a second rising edge.
        @(negedge clk); #1;
        pin_in = 8'hC3;
        @(posedge clk); #1;
        rd(2'd0, v); chk("R5 low-phase not yet", v, 8'h3C);
        @(posedge clk); #1;
        rd(2'd0, v); chk("R5 low-phase later", v, 8'hC3);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_readback();
        t_no_gap();
        t_gap();
        t_pin_read();
        t_capture_delay();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule